// File: doc/BRIEF.md
# Supply Voltage Detector Controller

This block is the digital side of one supply monitor channel. An analog comparator reports whether the supply sits below a programmed threshold. The block resynchronises that bit, samples it continuously or at intervals, and requires a run of consecutive detections before it raises a flag. The flag then drives either an interrupt request or a reset request. The threshold code goes back to the analog side on a dedicated output.

Software reaches the channel over a small word-addressed register bus. Writes to the control and clock registers land only while a system key register holds the unlock value. After the channel is switched on, or after the threshold is retuned while it is on, a settle timer holds the status as not valid for a parameterised number of cycles.

When the CPU is halted for debug, the whole channel freezes with its state intact. The exception is when a run-in-debug bit has been set, in which case the channel keeps running.

Top module: `svd_ctrl`

## Requirements
- R1: Register 1 (control) and register 2 (clock) accept writes only while register 0 holds 16'h0096. Any other value written to register 0 relocks them. Register 0 is always writable, and bit 0 of its read value is 1 exactly when the channel is unlocked.
- R2: While dbg_halt_i is 1 and the run-in-debug bit (register 2, bit 0) is 0, the channel takes no clock. The channel resumes when dbg_halt_i returns to 0. With the bit at 1, the channel keeps operating while halted.
- R3: While the channel is stopped for debug, bus writes to registers 1 to 3 are dropped, and the status, flag, enable and control state keep their values.
- R4: Control bit 1 selects the direction. At 0, the status reads 1 when a sample saw cmp_low_i = 1 (supply below threshold). At 1, it reads 1 when a sample saw cmp_low_i = 0. The status appears on det_o and on register 3, bit 2.
- R5: The flag (register 3, bit 0) is cleared by writing 1 to that bit. Register 3, bit 1 is the interrupt enable. In interrupt mode, irq_o is 1 exactly when both bits are 1.
- R6: Control bit 0 enables detection. While it is 0, no samples are taken, and both det_o and det_valid_o read 0.
- R7: Writing the enable bit from 0 to 1 holds det_valid_o low for EN_WAIT cycles. A write that changes the threshold while the channel stays enabled holds it low for THR_WAIT cycles. No sample is taken while det_valid_o is low.
- R8: Control bits 12:9 select the action. The value 4'hA selects reset mode, in which rst_req_o follows the flag and irq_o stays 0. Any other value selects interrupt mode, in which rst_req_o stays 0.
- R9: Control bits 3:2 = 0, 1, 2, 3 require 1, 2, 4 or 8 consecutive detecting samples before the flag sets. A non-detecting sample restarts the run.
- R10: Control bits 14:13 = 0 sample on every enabled cycle. The values 1, 2 and 3 sample once every 4, 16 or 64 cycles, counted from the point the status became valid.
- R11: After reset, all fields are 0, the channel is locked, and irq_o, rst_req_o, det_o and det_valid_o are 0.
- R12: cmp_low_i passes through two synchronising flops. A change on it reaches det_o no earlier than the third clock edge after the change.
- R13: thr_o always equals control bits 8:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Channel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_halt_i | input | 1 | CPU is in debug halt |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (read and write) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cmp_low_i | input | 1 | Comparator: supply below threshold |
| thr_o | output | 5 | Threshold code to the analog side |
| det_o | output | 1 | Latched detection status |
| det_valid_o | output | 1 | Status is settled and valid |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Reset request |

## Verification
The assertions check four properties on every cycle: a locked control write leaves the control register untouched, a debug stop freezes all channel state, a disabled channel clears its status, and interrupt and reset requests never coincide. They also check that a start or a retune drops validity, and that intermittent sampling never fires on back-to-back cycles. The bench's scenarios are needed for behaviour that spans many cycles. This covers the length of consecutive-detection runs, the restart of a run on a miss, and the 64-cycle sample spacing. It also covers the synchroniser delay, resumption after debug, and relocking by a wrong key. A behavioural model compares every output and the read data on each clock.

// File: rtl/svd_pkg.sv
package svd_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'h0096;
  localparam logic [3:0]  ACT_RESET  = 4'hA;

  typedef enum logic [1:0] {
    A_KEY  = 2'd0,
    A_CTRL = 2'd1,
    A_CLK  = 2'd2,
    A_INT  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] imode;
    logic [3:0] act;
    logic [4:0] thr;
    logic [1:0] cnt_sel;
    logic       dir;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/svd_sync.sv
module svd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   chain_q[i] <= 1'b0;
        else if (ce_i) chain_q[i] <= (i == 0) ? d_i : chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/svd_settle.sv
module svd_settle #(
  parameter int EN_WAIT  = 12,
  parameter int THR_WAIT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic en_i,
  input  logic start_i,
  input  logic retune_i,
  output logic valid_o
);
  localparam int MAXW = (EN_WAIT > THR_WAIT) ? EN_WAIT : THR_WAIT;
  localparam int TW   = $clog2(MAXW + 1);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tmr_q <= '0;
    else if (ce_i) begin
      if (start_i)          tmr_q <= TW'(EN_WAIT);
      else if (retune_i)    tmr_q <= TW'(THR_WAIT);
      else if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
    end
  end

  assign valid_o = en_i && (tmr_q == '0);

  AST_WAIT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && ((start_i && EN_WAIT > 0) || (retune_i && THR_WAIT > 0))) |=> !valid_o); // R7
endmodule

// File: rtl/svd_sampler.sv
module svd_sampler #(
  parameter int CNT_W = 4,
  parameter int DIV_W = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_i,
  input  logic       en_i,
  input  logic       valid_i,
  input  logic [1:0] imode_i,
  input  logic [1:0] cnt_sel_i,
  input  logic       raw_i,
  output logic       det_o,
  output logic       hit_o
);
  localparam logic [CNT_W-1:0] RUN_MAX = '1;

  logic [DIV_W-1:0] div_q, per_m1;
  logic [CNT_W-1:0] run_q, run_nxt, need;
  logic             tick, det_q;

  // one sample every 4^imode cycles
  always_comb begin
    case (imode_i)
      2'd0:    per_m1 = DIV_W'(0);
      2'd1:    per_m1 = DIV_W'(3);
      2'd2:    per_m1 = DIV_W'(15);
      default: per_m1 = DIV_W'(63);
    endcase
  end

  assign tick    = valid_i && ((imode_i == 2'd0) || (div_q == per_m1));
  assign need    = CNT_W'(1) << cnt_sel_i;
  assign run_nxt = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
  assign hit_o   = tick && raw_i && (run_nxt >= need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      run_q <= '0;
      det_q <= 1'b0;
    end else if (ce_i) begin
      if (!valid_i || tick) div_q <= '0;
      else                  div_q <= div_q + 1'b1;

      if (!en_i)     run_q <= '0;
      else if (tick) run_q <= raw_i ? run_nxt : '0;

      if (!en_i)     det_q <= 1'b0;
      else if (tick) det_q <= raw_i;
    end
  end

  assign det_o = det_q;

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && tick && imode_i != 2'd0) |=> (!tick || imode_i == 2'd0)); // R10
endmodule

// File: rtl/svd_ctrl.sv
module svd_ctrl
  import svd_pkg::*;
#(
  parameter int EN_WAIT     = 12,
  parameter int THR_WAIT    = 6,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dbg_halt_i,
  input  logic        wr_i,
  input  logic [1:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  input  logic        cmp_low_i,
  output logic [4:0]  thr_o,
  output logic        det_o,
  output logic        det_valid_o,
  output logic        irq_o,
  output logic        rst_req_o
);
  logic [15:0] key_q;
  ctrl_t       ctrl_q, ctrl_w;
  logic        run_dbg_q, flag_q, ie_q;
  logic        ce, unlocked, ctrl_wr, clk_wr, int_wr;
  logic        cmp_s, raw, hit, valid, start, retune, rst_mode;

  assign ce       = !(dbg_halt_i && !run_dbg_q);
  assign unlocked = (key_q == UNLOCK_KEY);
  assign ctrl_w   = ctrl_t'(wdata_i[14:0]);
  assign ctrl_wr  = wr_i && (addr_i == A_CTRL) && unlocked;
  assign clk_wr   = wr_i && (addr_i == A_CLK) && unlocked;
  assign int_wr   = wr_i && (addr_i == A_INT);
  assign start    = ctrl_wr && !ctrl_q.en && ctrl_w.en;
  assign retune   = ctrl_wr && ctrl_q.en && ctrl_w.en && (ctrl_w.thr != ctrl_q.thr);

  // key lives in the system domain: never frozen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          key_q <= '0;
    else if (wr_i && addr_i == A_KEY)     key_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      run_dbg_q <= 1'b0;
      flag_q    <= 1'b0;
      ie_q      <= 1'b0;
    end else if (ce) begin
      if (ctrl_wr) ctrl_q    <= ctrl_w;
      if (clk_wr)  run_dbg_q <= wdata_i[0];
      if (int_wr)  ie_q      <= wdata_i[1];
      if (hit)                        flag_q <= 1'b1;
      else if (int_wr && wdata_i[0])  flag_q <= 1'b0;
    end
  end

  svd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .ce_i (ce), .d_i (cmp_low_i), .q_o (cmp_s)
  );

  svd_settle #(.EN_WAIT(EN_WAIT), .THR_WAIT(THR_WAIT)) u_settle (
    .clk_i (clk_i), .rst_ni (rst_ni), .ce_i (ce), .en_i (ctrl_q.en),
    .start_i (start), .retune_i (retune), .valid_o (valid)
  );

  assign raw = ctrl_q.dir ? !cmp_s : cmp_s;

  svd_sampler #(.CNT_W(CNT_W)) u_sampler (
    .clk_i (clk_i), .rst_ni (rst_ni), .ce_i (ce), .en_i (ctrl_q.en),
    .valid_i (valid), .imode_i (ctrl_q.imode), .cnt_sel_i (ctrl_q.cnt_sel),
    .raw_i (raw), .det_o (det_o), .hit_o (hit)
  );

  assign rst_mode    = (ctrl_q.act == ACT_RESET);
  assign irq_o       = flag_q && ie_q && !rst_mode;
  assign rst_req_o   = flag_q && rst_mode;
  assign thr_o       = ctrl_q.thr;
  assign det_valid_o = valid;

  always_comb begin
    case (addr_i)
      A_KEY:   rdata_o = {15'd0, unlocked};
      A_CTRL:  rdata_o = {1'b0, ctrl_q};
      A_CLK:   rdata_o = {15'd0, run_dbg_q};
      default: rdata_o = {13'd0, det_o, ie_q, flag_q};
    endcase
  end

  AST_LOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce && wr_i && addr_i == A_CTRL && !unlocked) |=> $stable(ctrl_q)); // R1
  AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce |=> $stable({ctrl_q, run_dbg_q, flag_q, ie_q, det_o})); // R3
  AST_OFF_NO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce && !ctrl_q.en) |=> !det_o); // R6
  AST_REQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && rst_req_o)); // R8
endmodule

// File: tb/svd_ctrl_test.sv
module svd_ctrl_test;
  localparam int ENW = 12;
  localparam int THW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dbg = 1'b0, wr = 1'b0, cmp = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wd = '0, rd;
  logic [4:0] thr;
  logic det, dval, irq, rreq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  svd_ctrl #(.EN_WAIT(ENW), .THR_WAIT(THW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .dbg_halt_i(dbg), .wr_i(wr), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rd), .cmp_low_i(cmp), .thr_o(thr), .det_o(det),
    .det_valid_o(dval), .irq_o(irq), .rst_req_o(rreq)
  );

  // behavioural reference
  logic [15:0] m_key;
  int m_en, m_dir, m_cs, m_thr, m_act, m_im, m_rund, m_ie, m_flag;
  int m_s1, m_s2, m_div, m_tmr, m_run, m_det;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_key = '0; m_en = 0; m_dir = 0; m_cs = 0; m_thr = 0; m_act = 0; m_im = 0;
      m_rund = 0; m_ie = 0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_div = 0;
      m_tmr = 0; m_run = 0; m_det = 0;
    end else begin
      automatic bit ce = !(dbg && m_rund == 0);
      automatic bit unl = (m_key == 16'h0096);
      automatic bit vld = (m_en != 0) && (m_tmr == 0);
      automatic int per = (m_im == 0) ? 1 : (1 << (2 * m_im));
      automatic bit tick = vld && (m_im == 0 || m_div == per - 1);
      automatic bit d = (m_dir != 0) ? (m_s2 == 0) : (m_s2 != 0);
      automatic int runn = (m_run + 1 > 15) ? 15 : m_run + 1;
      automatic bit hit = tick && d && (runn >= (1 << m_cs));
      if (wr && addr == 2'd0) m_key = wd;
      if (ce) begin
        if (m_en == 0) begin m_det = 0; m_run = 0; end
        else if (tick) begin m_det = d; m_run = d ? runn : 0; end
        if (!vld || tick) m_div = 0; else m_div = m_div + 1;
        if (wr && addr == 2'd1 && unl && m_en == 0 && wd[0]) m_tmr = ENW;
        else if (wr && addr == 2'd1 && unl && m_en != 0 && wd[0] && int'(wd[8:4]) != m_thr) m_tmr = THW;
        else if (m_tmr > 0) m_tmr = m_tmr - 1;
        if (hit) m_flag = 1;
        else if (wr && addr == 2'd3 && wd[0]) m_flag = 0;
        if (wr && addr == 2'd3) m_ie = wd[1];
        if (wr && addr == 2'd2 && unl) m_rund = wd[0];
        if (wr && addr == 2'd1 && unl) begin
          m_en = wd[0]; m_dir = wd[1]; m_cs = wd[3:2]; m_thr = wd[8:4];
          m_act = wd[12:9]; m_im = wd[14:13];
        end
        m_s2 = m_s1; m_s1 = cmp;
      end
    end
  end

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {15'd0, m_key == 16'h0096};
      2'd1: return 16'(m_en | (m_dir << 1) | (m_cs << 2) | (m_thr << 4) | (m_act << 9) | (m_im << 13));
      2'd2: return 16'(m_rund);
      default: return 16'(m_flag | (m_ie << 1) | (m_det << 2));
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R4 det_o", det, m_det);
    chk("R7 det_valid_o", dval, (m_en != 0 && m_tmr == 0));
    chk("R5 irq_o", irq, (m_flag != 0 && m_ie != 0 && m_act != 10));
    chk("R8 rst_req_o", rreq, (m_flag != 0 && m_act == 10));
    chk("R13 thr_o", thr, m_thr);
    chk("R1 rdata_o", rd, m_read(addr));
  end

  task automatic wreg(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk); #1 wr = 1'b1; addr = a; wd = v;
    @(negedge clk); #1 wr = 1'b0;
  endtask
  task automatic rsel(input logic [1:0] a);
    @(negedge clk); #1 addr = a;
    @(negedge clk);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  function automatic logic [15:0] mk(input int en, dir, cs, th, act, im);
    return 16'(en | (dir << 1) | (cs << 2) | (th << 4) | (act << 9) | (im << 13));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic saved_det;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", irq, 0); chk("R11 rst_req", rreq, 0);
    chk("R11 valid", dval, 0); chk("R11 det", det, 0);
    rsel(2'd1); chk("R11 ctrl", rd, 0);
    // R1 locked write dropped
    wreg(2'd1, mk(1, 0, 0, 5, 0, 0));
    rsel(2'd1); chk("R1 locked ctrl", rd, 0);
    rsel(2'd0); chk("R1 lock bit", rd, 0);
    wreg(2'd0, 16'h0096);
    rsel(2'd0); chk("R1 unlock bit", rd, 1);
    wreg(2'd1, mk(1, 0, 0, 5, 0, 0));
    @(negedge clk); chk("R7 valid after start", dval, 0);
    wreg(2'd3, 16'h0003);
    idle(ENW + 2);
    chk("R7 valid settled", dval, 1);
    // R12 synchroniser delay
    @(negedge clk); #1 cmp = 1'b1;
    idle(2); chk("R12 det after two edges", det, 0);
    idle(1); chk("R12 det after three edges", det, 1);
    idle(2); chk("R5 irq set", irq, 1);
    #1 cmp = 1'b0; idle(4);
    wreg(2'd3, 16'h0003);
    @(negedge clk); chk("R5 irq cleared", irq, 0);
    // R4 rise direction
    wreg(2'd1, mk(1, 1, 0, 5, 0, 0));
    idle(3); chk("R4 rise det", det, 1);
    wreg(2'd1, mk(1, 0, 0, 5, 0, 0));
    wreg(2'd3, 16'h0003);
    // R7 retune
    wreg(2'd1, mk(1, 0, 0, 9, 0, 0));
    chk("R7 retune drop", dval, 0);
    idle(THW + 2); chk("R7 retune settled", dval, 1);
    // R9 run of eight needed
    wreg(2'd1, mk(1, 0, 3, 9, 0, 0));
    #1 cmp = 1'b1; idle(5); #1 cmp = 1'b0; idle(5);
    rsel(2'd3); chk("R9 short run no flag", rd[0], 0);
    #1 cmp = 1'b1; idle(14);
    chk("R9 full run flag", rd[0], 1);
    #1 cmp = 1'b0; idle(4);
    // R10 one sample per 64
    wreg(2'd1, mk(1, 0, 0, 9, 0, 3));
    wreg(2'd3, 16'h0003);
    #1 cmp = 1'b1; idle(20);
    rsel(2'd3); chk("R10 no early sample", rd[0], 0);
    idle(60); chk("R10 sample taken", rd[0], 1);
    #1 cmp = 1'b0;
    wreg(2'd1, mk(1, 0, 0, 9, 0, 0));
    idle(4); wreg(2'd3, 16'h0002);
    // R8 reset mode
    wreg(2'd1, mk(1, 0, 0, 9, 10, 0));
    #1 cmp = 1'b1; idle(5);
    chk("R8 reset req", rreq, 1); chk("R8 irq off", irq, 0);
    #1 cmp = 1'b0; idle(4);
    wreg(2'd1, mk(1, 0, 0, 9, 0, 0));
    wreg(2'd3, 16'h0003);
    // R3 freeze
    @(negedge clk); #1 dbg = 1'b1;
    saved_det = det;
    #1 cmp = 1'b1;
    wreg(2'd1, mk(0, 0, 0, 3, 0, 0));
    idle(10);
    chk("R3 det held", det, saved_det);
    rsel(2'd3); chk("R3 flag held", rd[0], 0);
    rsel(2'd1); chk("R3 ctrl held", rd, mk(1, 0, 0, 9, 0, 0));
    // R2 resume
    #1 dbg = 1'b0; idle(5);
    rsel(2'd3); chk("R2 resumed flag", rd[0], 1);
    #1 cmp = 1'b0;
    wreg(2'd2, 16'h0001);
    idle(4); wreg(2'd3, 16'h0003);
    #1 dbg = 1'b1; cmp = 1'b1; idle(6);
    rsel(2'd3); chk("R2 run in debug", rd[0], 1);
    #1 dbg = 1'b0; cmp = 1'b0;
    // R6 disable
    wreg(2'd1, mk(0, 0, 0, 9, 0, 0));
    @(negedge clk); chk("R6 valid off", dval, 0); chk("R6 det off", det, 0);
    // R1 relock
    wreg(2'd0, 16'h1234);
    wreg(2'd1, mk(1, 0, 0, 2, 0, 0));
    rsel(2'd1); chk("R1 relocked", rd, mk(0, 0, 0, 9, 0, 0));
    idle(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule